// File: doc/BRIEF.md
# Packet CRC Framer with Retry Marking

This block guards a word-oriented packet link with a 32-bit check code. On the transmit side it accepts packets of 32-bit words that are marked with start and end flags. It passes every word through a single output register and then adds one extra trailer word that holds the check code. The code is computed over all header and payload words. The sender can mark a packet for discard by asserting a poison input with the packet's last word. The trailer is then sent bit-inverted, so the far end rejects the packet and asks for it again.

On the receive side the block takes in the framed stream and recomputes the code. It removes the trailer and passes the header and payload words on. Alongside the last passed word it reports one verdict: good, mismatch, or inverted match (deliberate poison). Only mismatches are logged, in a sticky flag and a saturating counter. A mismatch never stops the link, and later packets are checked normally. While the link is in a synchronization phase, both directions pass packets unchanged and neither adds nor checks a trailer.

Transmit states: `TX_IDLE` (waiting for a start word), `TX_BODY` (forwarding words), `TX_TRAIL` (trailer pending). Transmit transitions: IDLE→BODY on an accepted start word that is not also an end word. IDLE→TRAIL on a one-word packet outside sync. BODY→TRAIL on an accepted end word outside sync. BODY→IDLE on an accepted end word in sync. TRAIL→IDLE once the trailer enters the output register. Receive states: `RX_IDLE`, `RX_PASS` (sync packet), `RX_HOLD` (checked packet, one word held back). Receive transitions: IDLE→PASS or IDLE→HOLD on a start word that is not an end word, chosen by the sync input. PASS→IDLE and HOLD→IDLE on an end word.

Top module: `crc_link_framer`

## Requirements
- R1: The check code uses polynomial 0x04C11DB7. It is processed MSB-first, with word bit 31 entering first. The register is seeded with 0xFFFFFFFF at each packet start. There is no bit reflection and no final XOR. The code covers every header and payload word of the packet.
- R2: Outside sync, the transmit output repeats the packet words in order and then adds one trailer word. `tx_out_sop` is set only on the first word. `tx_out_eop` is set only on the trailer.
- R3: If `tx_in_poison` is high together with the accepted end word, the trailer is the bitwise inverse of the correct code.
- R4: `link_sync` is sampled with each start word. For a sync packet, transmit and receive forward all words unchanged with their end flag, add or remove no trailer, and give no verdict.
- R5: While `tx_out_vld` is high and `tx_out_rdy` is low, the transmit output word and its flags stay unchanged and no word is lost.
- R6: Outside sync, the receive output repeats all words except the trailer. `rx_out_sop` is set on the first word and `rx_out_eop` on the last non-trailer word.
- R7: `rx_chk_vld` pulses once per checked packet, in the same cycle as the last output word. `rx_chk_code` reads 01 when the trailer matches, 11 when it is the exact inverse, and 10 otherwise.
- R8: A verdict of 10 sets `err_flag` and adds one to `err_count`, which stops at 255. Verdicts 01 and 11 are not logged. `err_clr` clears both and wins over a mismatch logged in the same cycle.
- R9: After a mismatch, the next packet is accepted and checked normally.
- R10: A valid word that arrives outside a packet without a start flag is dropped on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_sync | input | 1 | Link is in a synchronization phase (sampled at packet start) |
| tx_in_vld | input | 1 | Transmit input word valid |
| tx_in_rdy | output | 1 | Transmit input word accepted when high with valid |
| tx_in_data | input | 32 | Transmit input word |
| tx_in_sop | input | 1 | First word of a packet |
| tx_in_eop | input | 1 | Last word of a packet |
| tx_in_poison | input | 1 | Invert this packet's trailer (sampled with the end word) |
| tx_out_vld | output | 1 | Transmit output word valid |
| tx_out_rdy | input | 1 | Downstream accepts the transmit output word |
| tx_out_data | output | 32 | Transmit output word |
| tx_out_sop | output | 1 | First word of an outgoing packet |
| tx_out_eop | output | 1 | Last word (trailer) of an outgoing packet |
| rx_in_vld | input | 1 | Receive input word valid |
| rx_in_data | input | 32 | Receive input word |
| rx_in_sop | input | 1 | First word of a received packet |
| rx_in_eop | input | 1 | Last word (trailer) of a received packet |
| rx_out_vld | output | 1 | Receive output word valid |
| rx_out_data | output | 32 | Receive output word |
| rx_out_sop | output | 1 | First word of a passed packet |
| rx_out_eop | output | 1 | Last word of a passed packet |
| rx_chk_vld | output | 1 | Verdict valid pulse |
| rx_chk_code | output | 2 | Verdict: 01 good, 10 mismatch, 11 inverted |
| err_clr | input | 1 | Clear pulse for the error log |
| err_flag | output | 1 | Sticky mismatch flag |
| err_count | output | 8 | Saturating mismatch counter |

## Verification
The hardest case to reach is a clear pulse that lands in exactly the cycle in which a mismatch is being logged. The bench reaches it by raising `err_clr` on the falling edge right after the bad trailer has been sampled, with the counter already saturated at 255 from more than 255 bad packets in a row. A second hard case is a trailer held under backpressure. A repeating stall pattern on `tx_out_rdy` is applied during a full-length packet, and a monitor compares the held output word cycle by cycle.

// File: rtl/lnkcrc_pkg.sv
package lnkcrc_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_BODY  = 2'd1,
        TX_TRAIL = 2'd2
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_PASS = 2'd1,
        RX_HOLD = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        VERD_NONE   = 2'b00,
        VERD_GOOD   = 2'b01,
        VERD_BAD    = 2'b10,
        VERD_POISON = 2'b11
    } verdict_t;

    // Fold one word into the running code, MSB first.
    function automatic logic [WORD_W-1:0] crc_step(
        input logic [WORD_W-1:0] acc,
        input logic [WORD_W-1:0] word,
        input logic [WORD_W-1:0] poly
    );
        logic [WORD_W-1:0] c;
        c = acc;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (c[WORD_W-1] ^ word[i])
                c = (c << 1) ^ poly;
            else
                c = c << 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/lnkcrc_tx.sv
module lnkcrc_tx
    import lnkcrc_pkg::*;
#(
    parameter logic [WORD_W-1:0] POLY = 32'h04C11DB7,
    parameter logic [WORD_W-1:0] SEED = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_sync,
    input  logic              in_vld,
    output logic              in_rdy,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_poison,
    output logic              out_vld,
    input  logic              out_rdy,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop
);

    tx_state_t         st_q, st_nxt;
    logic [WORD_W-1:0] crc_q;
    logic              sync_q;
    logic              poison_q;
    logic              slot_free;
    logic              accept;

    assign slot_free = !out_vld || out_rdy;
    assign in_rdy    = slot_free && (st_q != TX_TRAIL);
    assign accept    = in_vld && in_rdy;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            TX_IDLE: begin
                if (accept && in_sop) begin
                    if (!in_eop)
                        st_nxt = TX_BODY;
                    else if (!link_sync)
                        st_nxt = TX_TRAIL;
                end
            end
            TX_BODY: begin
                if (accept && in_eop)
                    st_nxt = sync_q ? TX_IDLE : TX_TRAIL;
            end
            TX_TRAIL: begin
                if (slot_free)
                    st_nxt = TX_IDLE;
            end
            default: st_nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= TX_IDLE;
        else
            st_q <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_data <= '0;
            out_sop  <= 1'b0;
            out_eop  <= 1'b0;
            crc_q    <= SEED;
            sync_q   <= 1'b0;
            poison_q <= 1'b0;
        end else begin
            if (slot_free)
                out_vld <= 1'b0;
            unique case (st_q)
                TX_IDLE: begin
                    if (accept && in_sop) begin
                        out_vld  <= 1'b1;
                        out_data <= in_data;
                        out_sop  <= 1'b1;
                        out_eop  <= in_eop && link_sync;
                        crc_q    <= crc_step(SEED, in_data, POLY);
                        sync_q   <= link_sync;
                        poison_q <= in_poison;
                    end
                end
                TX_BODY: begin
                    if (accept) begin
                        out_vld  <= 1'b1;
                        out_data <= in_data;
                        out_sop  <= 1'b0;
                        out_eop  <= in_eop && sync_q;
                        crc_q    <= crc_step(crc_q, in_data, POLY);
                        if (in_eop)
                            poison_q <= in_poison;
                    end
                end
                TX_TRAIL: begin
                    if (slot_free) begin
                        out_vld  <= 1'b1;
                        out_data <= crc_q ^ {WORD_W{poison_q}};
                        out_sop  <= 1'b0;
                        out_eop  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lnkcrc_rx.sv
module lnkcrc_rx
    import lnkcrc_pkg::*;
#(
    parameter logic [WORD_W-1:0] POLY = 32'h04C11DB7,
    parameter logic [WORD_W-1:0] SEED = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_sync,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              chk_vld,
    output logic [1:0]        chk_code
);

    rx_state_t         st_q, st_nxt;
    logic [WORD_W-1:0] held_q;
    logic              held_sop_q;
    logic [WORD_W-1:0] crc_q;
    logic [WORD_W-1:0] crc_fold;

    assign crc_fold = crc_step(crc_q, held_q, POLY);

    function automatic logic [1:0] judge(
        input logic [WORD_W-1:0] exp_c,
        input logic [WORD_W-1:0] trailer
    );
        if (trailer == exp_c)
            return VERD_GOOD;
        else if (trailer == ~exp_c)
            return VERD_POISON;
        else
            return VERD_BAD;
    endfunction

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            RX_IDLE: begin
                if (in_vld && in_sop && !in_eop)
                    st_nxt = link_sync ? RX_PASS : RX_HOLD;
            end
            RX_PASS, RX_HOLD: begin
                if (in_vld && in_eop)
                    st_nxt = RX_IDLE;
            end
            default: st_nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= RX_IDLE;
        else
            st_q <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld    <= 1'b0;
            out_data   <= '0;
            out_sop    <= 1'b0;
            out_eop    <= 1'b0;
            chk_vld    <= 1'b0;
            chk_code   <= VERD_NONE;
            held_q     <= '0;
            held_sop_q <= 1'b0;
            crc_q      <= SEED;
        end else begin
            out_vld <= 1'b0;
            chk_vld <= 1'b0;
            unique case (st_q)
                RX_IDLE: begin
                    if (in_vld && in_sop) begin
                        if (link_sync) begin
                            out_vld  <= 1'b1;
                            out_data <= in_data;
                            out_sop  <= 1'b1;
                            out_eop  <= in_eop;
                        end else if (in_eop) begin
                            chk_vld  <= 1'b1;
                            chk_code <= judge(SEED, in_data);
                        end else begin
                            held_q     <= in_data;
                            held_sop_q <= 1'b1;
                            crc_q      <= SEED;
                        end
                    end
                end
                RX_PASS: begin
                    if (in_vld) begin
                        out_vld  <= 1'b1;
                        out_data <= in_data;
                        out_sop  <= 1'b0;
                        out_eop  <= in_eop;
                    end
                end
                RX_HOLD: begin
                    if (in_vld) begin
                        out_vld    <= 1'b1;
                        out_data   <= held_q;
                        out_sop    <= held_sop_q;
                        out_eop    <= in_eop;
                        held_sop_q <= 1'b0;
                        if (in_eop) begin
                            chk_vld  <= 1'b1;
                            chk_code <= judge(crc_fold, in_data);
                        end else begin
                            crc_q  <= crc_fold;
                            held_q <= in_data;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lnkcrc_errlog.sv
module lnkcrc_errlog #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ev,
    output logic             flag,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flag  <= 1'b0;
            count <= '0;
        end else if (ev) begin
            flag <= 1'b1;
            if (count != CNT_MAX)
                count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/crc_link_framer.sv
module crc_link_framer
    import lnkcrc_pkg::*;
#(
    parameter logic [31:0] CRC_POLY  = 32'h04C11DB7,
    parameter logic [31:0] CRC_SEED  = 32'hFFFFFFFF,
    parameter int          ERR_CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_sync,
    input  logic                 tx_in_vld,
    output logic                 tx_in_rdy,
    input  logic [31:0]          tx_in_data,
    input  logic                 tx_in_sop,
    input  logic                 tx_in_eop,
    input  logic                 tx_in_poison,
    output logic                 tx_out_vld,
    input  logic                 tx_out_rdy,
    output logic [31:0]          tx_out_data,
    output logic                 tx_out_sop,
    output logic                 tx_out_eop,
    input  logic                 rx_in_vld,
    input  logic [31:0]          rx_in_data,
    input  logic                 rx_in_sop,
    input  logic                 rx_in_eop,
    output logic                 rx_out_vld,
    output logic [31:0]          rx_out_data,
    output logic                 rx_out_sop,
    output logic                 rx_out_eop,
    output logic                 rx_chk_vld,
    output logic [1:0]           rx_chk_code,
    input  logic                 err_clr,
    output logic                 err_flag,
    output logic [ERR_CNT_W-1:0] err_count
);

    logic mismatch_ev;

    lnkcrc_tx #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_sync(link_sync),
        .in_vld   (tx_in_vld),
        .in_rdy   (tx_in_rdy),
        .in_data  (tx_in_data),
        .in_sop   (tx_in_sop),
        .in_eop   (tx_in_eop),
        .in_poison(tx_in_poison),
        .out_vld  (tx_out_vld),
        .out_rdy  (tx_out_rdy),
        .out_data (tx_out_data),
        .out_sop  (tx_out_sop),
        .out_eop  (tx_out_eop)
    );

    lnkcrc_rx #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_sync(link_sync),
        .in_vld   (rx_in_vld),
        .in_data  (rx_in_data),
        .in_sop   (rx_in_sop),
        .in_eop   (rx_in_eop),
        .out_vld  (rx_out_vld),
        .out_data (rx_out_data),
        .out_sop  (rx_out_sop),
        .out_eop  (rx_out_eop),
        .chk_vld  (rx_chk_vld),
        .chk_code (rx_chk_code)
    );

    assign mismatch_ev = rx_chk_vld && (rx_chk_code == VERD_BAD);

    lnkcrc_errlog #(.CNT_W(ERR_CNT_W)) u_log (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (err_clr),
        .ev   (mismatch_ev),
        .flag (err_flag),
        .count(err_count)
    );

endmodule

// File: rtl/crc_link_framer_chk.sv
module crc_link_framer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_out_vld,
    input logic             tx_out_rdy,
    input logic [31:0]      tx_out_data,
    input logic             tx_out_sop,
    input logic             tx_out_eop,
    input logic             rx_out_vld,
    input logic             rx_out_eop,
    input logic             rx_chk_vld,
    input logic [1:0]       rx_chk_code,
    input logic             err_clr,
    input logic             err_flag,
    input logic [CNT_W-1:0] err_count
);

    // R5
    tx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_vld && !tx_out_rdy |=> tx_out_vld && $stable(tx_out_data)
            && $stable(tx_out_sop) && $stable(tx_out_eop));

    // R7
    verdict_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_chk_vld |-> rx_chk_code != 2'b00);

    // R7
    verdict_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_chk_vld && rx_out_vld |-> rx_out_eop);

    // R8
    err_cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(err_clr) |-> err_count >= $past(err_count));

    // R8
    err_flag_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_count != '0 |-> err_flag);

    // R8
    bad_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_chk_vld && rx_chk_code == 2'b10 && !err_clr |=> err_flag);

endmodule

bind crc_link_framer crc_link_framer_chk #(.CNT_W(ERR_CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_out_vld (tx_out_vld),
    .tx_out_rdy (tx_out_rdy),
    .tx_out_data(tx_out_data),
    .tx_out_sop (tx_out_sop),
    .tx_out_eop (tx_out_eop),
    .rx_out_vld (rx_out_vld),
    .rx_out_eop (rx_out_eop),
    .rx_chk_vld (rx_chk_vld),
    .rx_chk_code(rx_chk_code),
    .err_clr    (err_clr),
    .err_flag   (err_flag),
    .err_count  (err_count)
);

// File: tb/crc_link_framer_test.sv
`timescale 1ns/1ps
module crc_link_framer_test;

    localparam logic [31:0] POLY = 32'h04C11DB7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_sync = 1'b0;
    logic        tx_in_vld = 1'b0;
    logic        tx_in_rdy;
    logic [31:0] tx_in_data = '0;
    logic        tx_in_sop = 1'b0;
    logic        tx_in_eop = 1'b0;
    logic        tx_in_poison = 1'b0;
    logic        tx_out_vld;
    logic        tx_out_rdy = 1'b1;
    logic [31:0] tx_out_data;
    logic        tx_out_sop;
    logic        tx_out_eop;
    logic        rx_in_vld = 1'b0;
    logic [31:0] rx_in_data = '0;
    logic        rx_in_sop = 1'b0;
    logic        rx_in_eop = 1'b0;
    logic        rx_out_vld;
    logic [31:0] rx_out_data;
    logic        rx_out_sop;
    logic        rx_out_eop;
    logic        rx_chk_vld;
    logic [1:0]  rx_chk_code;
    logic        err_clr = 1'b0;
    logic        err_flag;
    logic [7:0]  err_count;

    crc_link_framer uut (.*);

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [31:0] pkt [0:31];
    logic [31:0] tx_d [0:63];
    logic        tx_s [0:63];
    logic        tx_e [0:63];
    int          tx_n = 0;
    logic [31:0] rx_d [0:63];
    logic        rx_s [0:63];
    logic        rx_e [0:63];
    int          rx_n = 0;
    logic [1:0]  vcode [0:7];
    int          v_n = 0;
    int          stab_bad = 0;
    bit          stall_en = 0;
    int          cyc = 0;

    logic        was_stalled = 0;
    logic [31:0] prev_d;
    logic        prev_e;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int w = 0; w < n; w++)
            for (int b = 31; b >= 0; b--)
                c = (c[31] ^ pkt[w][b]) ? ((c << 1) ^ POLY) : (c << 1);
        return c;
    endfunction

    // output ready pattern, changed between edges
    always begin
        @(posedge clk);
        #1;
        cyc++;
        tx_out_rdy = !stall_en || ((cyc % 5) > 1);
    end

    always @(negedge clk) begin
        if (was_stalled && (!tx_out_vld || tx_out_data !== prev_d || tx_out_eop !== prev_e))
            stab_bad++;
        was_stalled = tx_out_vld && !tx_out_rdy;
        prev_d = tx_out_data;
        prev_e = tx_out_eop;
        if (tx_out_vld && tx_out_rdy) begin
            if (tx_n < 64) begin
                tx_d[tx_n] = tx_out_data; tx_s[tx_n] = tx_out_sop; tx_e[tx_n] = tx_out_eop;
            end
            tx_n++;
        end
        if (rx_out_vld) begin
            if (rx_n < 64) begin
                rx_d[rx_n] = rx_out_data; rx_s[rx_n] = rx_out_sop; rx_e[rx_n] = rx_out_eop;
            end
            rx_n++;
        end
        if (rx_chk_vld) begin
            if (v_n < 8) vcode[v_n] = rx_chk_code;
            v_n++;
        end
    end

    task automatic clear_caps();
        tx_n = 0; rx_n = 0; v_n = 0; stab_bad = 0;
    endtask

    task automatic tx_word(input logic [31:0] d, input logic s, input logic e, input logic p);
        logic took;
        took = 0;
        @(negedge clk);
        tx_in_vld = 1; tx_in_data = d; tx_in_sop = s; tx_in_eop = e; tx_in_poison = p;
        while (!took) begin
            #1;
            took = tx_in_rdy;
            @(negedge clk);
        end
        tx_in_vld = 0; tx_in_poison = 0;
    endtask

    task automatic tx_packet(input int n, input logic p);
        for (int i = 0; i < n; i++)
            tx_word(pkt[i], i == 0, i == n - 1, p);
        repeat (12) @(negedge clk);
    endtask

    task automatic rx_word(input logic [31:0] d, input logic s, input logic e);
        @(negedge clk);
        rx_in_vld = 1; rx_in_data = d; rx_in_sop = s; rx_in_eop = e;
    endtask

    // sends pkt[0..n-1] then a trailer word; optional clear in the logging cycle
    task automatic rx_packet(input int n, input logic [31:0] trailer, input bit clr_hit);
        for (int i = 0; i < n; i++)
            rx_word(pkt[i], i == 0, 1'b0);
        rx_word(trailer, n == 0, 1'b1);
        @(negedge clk);
        rx_in_vld = 0;
        if (clr_hit) begin
            err_clr = 1;
            @(negedge clk);
            err_clr = 0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic fill(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++)
            pkt[i] = base ^ (32'h9E3779B9 * (i + 1));
    endtask

    task automatic t_reset();
        check("R8 reset tx_out_vld", {31'b0, tx_out_vld}, 0);
        check("R8 reset rx_out_vld", {31'b0, rx_out_vld}, 0);
        check("R8 reset err_flag", {31'b0, err_flag}, 0);
        check("R8 reset err_count", {24'b0, err_count}, 0);
        check("R5 reset tx_in_rdy", {31'b0, tx_in_rdy}, 1);
    endtask

    task automatic t_tx_basic();
        logic [31:0] c;
        clear_caps(); fill(3, 32'h1234_0000);
        c = ref_crc(3);
        tx_packet(3, 0);
        check("R2 tx word count", tx_n, 4);
        for (int i = 0; i < 3; i++) begin
            check("R2 tx word", tx_d[i], pkt[i]);
            check("R2 tx eop", {31'b0, tx_e[i]}, 0);
        end
        check("R2 tx sop first", {31'b0, tx_s[0]}, 1);
        check("R2 tx sop later", {31'b0, tx_s[1]}, 0);
        check("R1 tx trailer", tx_d[3], c);
        check("R2 tx trailer eop", {31'b0, tx_e[3]}, 1);
        // one-word packet
        clear_caps(); pkt[0] = 32'hDEAD_BEEF; c = ref_crc(1);
        tx_packet(1, 0);
        check("R2 one-word count", tx_n, 2);
        check("R1 one-word trailer", tx_d[1], c);
    endtask

    task automatic t_tx_poison();
        logic [31:0] c;
        clear_caps(); fill(2, 32'hA5A5_0000);
        c = ref_crc(2);
        tx_packet(2, 1);
        check("R3 poison count", tx_n, 3);
        check("R3 poison trailer", tx_d[2], ~c);
    endtask

    task automatic t_tx_stall();
        logic [31:0] c;
        clear_caps(); fill(18, 32'h0F0F_3C3C);
        c = ref_crc(18);
        stall_en = 1;
        tx_packet(18, 0);
        repeat (20) @(negedge clk);
        stall_en = 0;
        check("R5 stall count", tx_n, 19);
        for (int i = 0; i < 18; i++)
            check("R5 stall word", tx_d[i], pkt[i]);
        check("R1 stall trailer", tx_d[18], c);
        check("R5 held stable", stab_bad, 0);
    endtask

    task automatic t_tx_sync();
        clear_caps(); fill(3, 32'h5555_0001);
        @(negedge clk); link_sync = 1;
        tx_packet(3, 0);
        link_sync = 0;
        check("R4 tx sync count", tx_n, 3);
        check("R4 tx sync last", tx_d[2], pkt[2]);
        check("R4 tx sync eop", {31'b0, tx_e[2]}, 1);
    endtask

    task automatic t_stray();
        clear_caps();
        tx_word(32'h1111_2222, 0, 0, 0);
        rx_word(32'h3333_4444, 0, 0);
        @(negedge clk); rx_in_vld = 0;
        repeat (5) @(negedge clk);
        check("R10 tx stray dropped", tx_n, 0);
        check("R10 rx stray dropped", rx_n, 0);
        check("R10 rx stray no verdict", v_n, 0);
    endtask

    task automatic t_rx_good();
        clear_caps(); fill(3, 32'hCAFE_0000);
        rx_packet(3, ref_crc(3), 0);
        check("R6 rx count", rx_n, 3);
        for (int i = 0; i < 3; i++)
            check("R6 rx word", rx_d[i], pkt[i]);
        check("R6 rx sop", {31'b0, rx_s[0]}, 1);
        check("R6 rx eop", {31'b0, rx_e[2]}, 1);
        check("R6 rx eop mid", {31'b0, rx_e[1]}, 0);
        check("R7 good verdicts", v_n, 1);
        check("R7 good code", {30'b0, vcode[0]}, 32'h1);
        check("R8 good not logged", {24'b0, err_count}, 0);
    endtask

    task automatic t_rx_poison();
        clear_caps(); fill(2, 32'hBEEF_0000);
        rx_packet(2, ~ref_crc(2), 0);
        check("R7 poison code", {30'b0, vcode[0]}, 32'h3);
        check("R8 poison not logged", {31'b0, err_flag}, 0);
    endtask

    task automatic t_rx_bad();
        clear_caps(); fill(4, 32'h7777_0000);
        rx_packet(4, ref_crc(4) ^ 32'h0000_0100, 0);
        check("R7 bad code", {30'b0, vcode[0]}, 32'h2);
        check("R6 bad still passed", rx_n, 4);
        check("R8 bad flag", {31'b0, err_flag}, 1);
        check("R8 bad count", {24'b0, err_count}, 1);
        clear_caps(); fill(2, 32'h0102_0304);
        rx_packet(2, ref_crc(2), 0);
        check("R9 next packet good", {30'b0, vcode[0]}, 32'h1);
        check("R9 count unchanged", {24'b0, err_count}, 1);
    endtask

    task automatic t_rx_sync();
        clear_caps(); fill(3, 32'h2468_0000);
        @(negedge clk); link_sync = 1;
        for (int i = 0; i < 3; i++)
            rx_word(pkt[i], i == 0, i == 2);
        @(negedge clk); rx_in_vld = 0;
        repeat (3) @(negedge clk);
        link_sync = 0;
        check("R4 rx sync count", rx_n, 3);
        check("R4 rx sync last", rx_d[2], pkt[2]);
        check("R4 rx sync eop", {31'b0, rx_e[2]}, 1);
        check("R4 rx sync no verdict", v_n, 0);
    endtask

    task automatic t_loop();
        clear_caps(); fill(18, 32'h600D_F00D);
        tx_packet(18, 0);
        check("R1 loop tx count", tx_n, 19);
        for (int i = 0; i < 18; i++)
            pkt[i] = tx_d[i];
        rx_packet(18, tx_d[18], 0);
        check("R1 loop verdict", {30'b0, vcode[0]}, 32'h1);
        check("R6 loop count", rx_n, 18);
    endtask

    task automatic t_clear();
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        check("R8 clr flag", {31'b0, err_flag}, 0);
        check("R8 clr count", {24'b0, err_count}, 0);
    endtask

    task automatic t_saturate();
        pkt[0] = 32'h0BAD_0BAD;
        for (int k = 0; k < 260; k++)
            rx_packet(1, 32'h0, 0);
        check("R8 saturate count", {24'b0, err_count}, 255);
        check("R8 saturate flag", {31'b0, err_flag}, 1);
    endtask

    task automatic t_collide();
        pkt[0] = 32'h0BAD_0BAD;
        rx_packet(1, 32'h0, 1);
        check("R8 clear wins count", {24'b0, err_count}, 0);
        check("R8 clear wins flag", {31'b0, err_flag}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tx_basic();
        t_tx_poison();
        t_tx_stall();
        t_tx_sync();
        t_stray();
        t_rx_good();
        t_rx_poison();
        t_rx_bad();
        t_rx_sync();
        t_loop();
        t_clear();
        t_saturate();
        t_collide();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule